// File: doc/BRIEF.md
# Multi-mode register-mapped UART

This block is an asynchronous serial controller that sits on a small register bus. Software sets the frame format in a control register. It writes bytes into a one-deep transmit holding register, which hands each byte to a shifter. Received bytes are read from a receive buffer. A status register reports the buffer states and a sticky error condition, and it holds the two interrupt enables. Bit timing comes from a programmable divisor. The divisor produces a 16x oversampling tick, so every bit on the line lasts 16 ticks.

There are three frame formats. Mode code 00 carries 7 data bits and mode code 01 carries 8. Mode code 11 carries 8 data bits plus a ninth slot. When parity is on, that ninth slot holds parity. When parity is off, it holds a ninth data bit that software supplies on transmit and reads back on receive. In the other two modes, parity adds one optional bit after the data.

The register bus accepts every access in the cycle it is presented and applies no back-pressure. Flow control is left to software through the flags: transmit writes made while the holding register is full are dropped, and a frame that arrives while the receive buffer is full is reported as an error. Registers:
- address 0: control, read/write
- address 1: status
- address 2: receive data, read
- address 3: transmit data, write
- address 4: divisor

Top module: `sio_uart`

## Requirements
- R1: The line idles high. A frame is a low start bit, then the data bits least significant first, then the optional slot, then the high stop bit(s). Each bit lasts 16 ticks, and a tick occurs every (divisor+1) clocks, where the divisor is set at address 4.
- R2: Control bits [1:0] select the mode: 00 gives 7 data bits, 01 gives 8, and 11 gives 8 data bits plus a ninth slot. A control write whose bits [1:0] are 10 is ignored entirely, and the control register keeps its previous value.
- R3: With control bit 2 set (parity on), a slot follows the data holding the XOR of the data bits XORed with control bit 3 (1 selects odd parity). In mode 11 with parity off, the slot carries control bit 6 on transmit, and the received slot is stored in status bit 5.
- R4: Control bit 4 selects two stop bits instead of one. With a second byte already waiting, the start edges of consecutive frames are 16×(frame length)+1 clocks apart at divisor 0.
- R5: A write to address 3 while status bit 2 (transmit empty) is 1 stores the byte and clears the flag. The flag returns to 1 once the shifter takes the byte. A write made while the flag is 0 is dropped and never sent.
- R6: tx_irq_o equals transmit-empty AND status bit 3 (transmit interrupt enable).
- R7: While control bit 5 (output enable) is 0, txd_o stays high, even though bytes are still consumed.
- R8: The receiver starts on a falling edge and confirms it at mid start bit, so a low pulse shorter than half a bit is ignored. It samples each bit at mid-period. After the stop bit it sets status bit 0 (receive full), with the data at address 2 (bit 7 reads 0 in mode 00). Reading address 2 clears status bit 0.
- R9: Status bit 1 (error) is set when a frame completes while receive full is set, and the buffered data is kept. It is also set when the stop bit is sampled low. It stays set until a status write with bit 1 equal to 1.
- R10: rx_irq_o equals (receive full OR error) AND status bit 4 (receive interrupt enable).
- R11: After reset, txd_o is 1, control and divisor read 0, status reads 0x04, and both interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, used for the side effect of reading receive data |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| rxd_i | input | 1 | Serial input, asynchronous |
| txd_o | output | 1 | Serial output |
| tx_irq_o | output | 1 | Transmit interrupt request |
| rx_irq_o | output | 1 | Receive interrupt request |

## Verification
The hardest condition to reach from the ports is a receive overrun with a known ninth bit, checked for every frame format. The bench therefore loops txd_o back to rxd_i. For every mode and option combination, it queues two bytes back to back, so the second frame always lands on a full buffer. It then checks the decoded line bits, the start-to-start spacing, the kept first byte, the stored ninth bit and the error flag. Framing errors and sub-half-bit glitches cannot come from the transmitter, so the bench drives those on rxd_i itself.

// File: rtl/sio_uart_pkg.sv
package sio_uart_pkg;

  localparam int unsigned OVS       = 16;
  localparam int unsigned OVS_W     = $clog2(OVS);
  localparam int unsigned DATA_MAX  = 8;
  localparam int unsigned DSEL_W    = $clog2(DATA_MAX);
  localparam int unsigned FRAME_MAX = 1 + DATA_MAX + 1 + 2;
  localparam int unsigned FRAME_W   = $clog2(FRAME_MAX + 1);
  localparam int unsigned IDX_W     = $clog2(DATA_MAX + 2);

  typedef enum logic [1:0] {
    MODE_D7   = 2'b00,
    MODE_D8   = 2'b01,
    MODE_RSVD = 2'b10,
    MODE_D9   = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_STAT = 3'd1,
    REG_RXD  = 3'd2,
    REG_TXD  = 3'd3,
    REG_DIV  = 3'd4
  } reg_e;

  typedef struct packed {
    logic  ninth;
    logic  out_en;
    logic  two_stop;
    logic  par_odd;
    logic  par_en;
    mode_e mode;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  function automatic logic [3:0] data_len(input mode_e m);
    return (m == MODE_D7) ? 4'd7 : 4'd8;
  endfunction

  function automatic logic has_slot(input mode_e m, input logic par_en);
    return par_en || (m == MODE_D9);
  endfunction

endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q == div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick_o || (cnt_q > div_i)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_uart_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  ctrl_t               ctrl_i,
  input  logic                load_i,
  input  logic [DATA_MAX-1:0] data_i,
  output logic                busy_o,
  output logic                txd_o
);

  logic [FRAME_MAX-1:0] frame;
  logic [FRAME_MAX-1:0] sh_q;
  logic [FRAME_W-1:0]   len;
  logic [FRAME_W-1:0]   left_q;
  logic [OVS_W-1:0]     tcnt_q;
  logic [3:0]           nd;
  logic                 slot;
  logic                 par;

  // Assemble the whole frame at load time; upper bits default to stop level.
  always_comb begin
    nd   = data_len(ctrl_i.mode);
    slot = has_slot(ctrl_i.mode, ctrl_i.par_en);
    par  = ctrl_i.par_odd;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < int'(nd)) par ^= data_i[i];
    end
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < int'(nd)) frame[i+1] = data_i[i];
    end
    for (int i = 0; i < FRAME_MAX; i++) begin
      if (slot && (i == int'(nd) + 1)) frame[i] = ctrl_i.par_en ? par : ctrl_i.ninth;
    end
    len = FRAME_W'(1) + FRAME_W'(nd) + FRAME_W'(slot)
        + (ctrl_i.two_stop ? FRAME_W'(2) : FRAME_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      tcnt_q <= '0;
    end else if (!busy_o) begin
      if (load_i) begin
        busy_o <= 1'b1;
        sh_q   <= frame;
        left_q <= len;
        tcnt_q <= '0;
      end
    end else if (tick_i) begin
      if (tcnt_q == OVS_W'(OVS - 1)) begin
        tcnt_q <= '0;
        sh_q   <= {1'b1, sh_q[FRAME_MAX-1:1]};
        left_q <= left_q - 1'b1;
        if (left_q == FRAME_W'(1)) busy_o <= 1'b0;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  assign txd_o = !ctrl_i.out_en || !busy_o || sh_q[0];

endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_uart_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                rxd_i,
  input  mode_e               mode_i,
  input  logic                par_en_i,
  output logic                done_o,
  output logic [DATA_MAX-1:0] data_o,
  output logic                slot_o,
  output logic                slot_is_ninth_o,
  output logic                stop_ok_o
);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_e;

  rx_state_e        state_q;
  logic             prev_q;
  logic [OVS_W-1:0] tcnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] nbits_q;
  logic [IDX_W-1:0] nd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q         <= RX_IDLE;
      prev_q          <= 1'b1;
      tcnt_q          <= '0;
      idx_q           <= '0;
      nbits_q         <= '0;
      nd_q            <= '0;
      data_o          <= '0;
      slot_o          <= 1'b0;
      slot_is_ninth_o <= 1'b0;
      stop_ok_o       <= 1'b0;
      done_o          <= 1'b0;
    end else begin
      prev_q <= rxd_i;
      done_o <= 1'b0;
      unique case (state_q)
        RX_IDLE: begin
          if (prev_q && !rxd_i) begin
            state_q         <= RX_START;
            tcnt_q          <= '0;
            idx_q           <= '0;
            data_o          <= '0;
            nd_q            <= IDX_W'(data_len(mode_i));
            nbits_q         <= IDX_W'(data_len(mode_i)) + IDX_W'(has_slot(mode_i, par_en_i));
            slot_is_ninth_o <= (mode_i == MODE_D9) && !par_en_i;
          end
        end
        RX_START: begin
          if (tick_i) begin
            if (tcnt_q == OVS_W'(OVS/2 - 1)) begin
              tcnt_q  <= '0;
              state_q <= rxd_i ? RX_IDLE : RX_BITS;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        RX_BITS: begin
          if (tick_i) begin
            if (tcnt_q == OVS_W'(OVS - 1)) begin
              tcnt_q <= '0;
              if (idx_q < nd_q) data_o[idx_q[DSEL_W-1:0]] <= rxd_i;
              else              slot_o <= rxd_i;
              idx_q <= idx_q + 1'b1;
              if (idx_q == nbits_q - 1'b1) state_q <= RX_STOP;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick_i) begin
            if (tcnt_q == OVS_W'(OVS - 1)) begin
              tcnt_q    <= '0;
              done_o    <= 1'b1;
              stop_ok_o <= rxd_i;
              state_q   <= RX_IDLE;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        default: state_q <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sio_uart.sv
module sio_uart
  import sio_uart_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  input  logic             rxd_i,
  output logic             txd_o,
  output logic             tx_irq_o,
  output logic             rx_irq_o
);

  reg_e                addr_e;
  ctrl_t               ctrl_q;
  ctrl_t               ctrl_new;
  logic [DIV_W-1:0]    div_q;
  logic [DATA_MAX-1:0] thr_q;
  logic [DATA_MAX-1:0] rxbuf_q;
  logic                tx_empty_q, tx_ie_q, rx_ie_q;
  logic                rx_full_q, err_q, rx9_q;
  logic [1:0]          sync_q;
  logic                tick, tx_busy, tx_load;
  logic                wr_ctrl, wr_stat, wr_txd, wr_div, rd_rxd, full_after_rd;
  logic                rx_done, rx_slot, rx_nin, rx_stop_ok;
  logic [DATA_MAX-1:0] rx_data;

  assign addr_e   = reg_e'(reg_addr);
  assign ctrl_new = ctrl_t'(reg_wdata[CTRL_W-1:0]);
  assign wr_ctrl  = reg_wr && (addr_e == REG_CTRL);
  assign wr_stat  = reg_wr && (addr_e == REG_STAT);
  assign wr_txd   = reg_wr && (addr_e == REG_TXD);
  assign wr_div   = reg_wr && (addr_e == REG_DIV);
  assign rd_rxd   = reg_rd && (addr_e == REG_RXD);
  assign tx_load  = !tx_empty_q && !tx_busy;
  assign full_after_rd = rx_full_q && !rd_rxd;

  sio_baud #(.DIV_W(DIV_W)) u_baud (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_i  (div_q),
    .tick_o (tick)
  );

  sio_tx u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .ctrl_i (ctrl_q),
    .load_i (tx_load),
    .data_i (thr_q),
    .busy_o (tx_busy),
    .txd_o  (txd_o)
  );

  sio_rx u_rx (
    .clk             (clk),
    .rst_n           (rst_n),
    .tick_i          (tick),
    .rxd_i           (sync_q[1]),
    .mode_i          (ctrl_q.mode),
    .par_en_i        (ctrl_q.par_en),
    .done_o          (rx_done),
    .data_o          (rx_data),
    .slot_o          (rx_slot),
    .slot_is_ninth_o (rx_nin),
    .stop_ok_o       (rx_stop_ok)
  );

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      div_q   <= '0;
      tx_ie_q <= 1'b0;
      rx_ie_q <= 1'b0;
    end else begin
      if (wr_ctrl && (ctrl_new.mode != MODE_RSVD)) ctrl_q <= ctrl_new;
      if (wr_div) div_q <= reg_wdata[DIV_W-1:0];
      if (wr_stat) begin
        tx_ie_q <= reg_wdata[3];
        rx_ie_q <= reg_wdata[4];
      end
    end
  end

  // Transmit holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q      <= '0;
      tx_empty_q <= 1'b1;
    end else if (wr_txd && tx_empty_q) begin
      thr_q      <= reg_wdata[DATA_MAX-1:0];
      tx_empty_q <= 1'b0;
    end else if (tx_load) begin
      tx_empty_q <= 1'b1;
    end
  end

  // Receive side: synchroniser, buffer and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= 2'b11;
      rxbuf_q   <= '0;
      rx_full_q <= 1'b0;
      err_q     <= 1'b0;
      rx9_q     <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      if (wr_stat && reg_wdata[1]) err_q <= 1'b0;
      if (rx_done) begin
        if (full_after_rd) begin
          err_q <= 1'b1;
        end else begin
          rxbuf_q   <= rx_data;
          rx_full_q <= 1'b1;
          if (rx_nin)      rx9_q <= rx_slot;
          if (!rx_stop_ok) err_q <= 1'b1;
        end
      end else if (rd_rxd) begin
        rx_full_q <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (addr_e)
      REG_CTRL: reg_rdata[CTRL_W-1:0]   = ctrl_q;
      REG_STAT: reg_rdata[5:0]          = {rx9_q, rx_ie_q, tx_ie_q, tx_empty_q, err_q, rx_full_q};
      REG_RXD:  reg_rdata[DATA_MAX-1:0] = rxbuf_q;
      REG_DIV:  reg_rdata[DIV_W-1:0]    = div_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign tx_irq_o = tx_empty_q && tx_ie_q;
  assign rx_irq_o = (rx_full_q || err_q) && rx_ie_q;

endmodule

// File: rtl/sio_uart_chk.sv
module sio_uart_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] reg_addr,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [1:0] wdata_lo,
  input logic       txd_o,
  input logic [1:0] mode,
  input logic       out_en,
  input logic       tx_empty,
  input logic       tx_busy,
  input logic       rx_full,
  input logic       rx_done,
  input logic       err
);

  assert_rsvd_mode_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && wdata_lo == 2'b10) |=> $stable(mode));

  assert_tx_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd3 && tx_empty) |=> !tx_empty);

  assert_empty_rises_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> $rose(tx_busy));

  assert_line_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd_o);

  assert_out_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> txd_o);

  assert_read_clears_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd2 && !rx_done) |=> !rx_full);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(reg_wr && reg_addr == 3'd1 && wdata_lo[1])) |=> err);

endmodule

bind sio_uart sio_uart_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_addr (reg_addr),
  .reg_wr   (reg_wr),
  .reg_rd   (reg_rd),
  .wdata_lo (reg_wdata[1:0]),
  .txd_o    (txd_o),
  .mode     (ctrl_q.mode),
  .out_en   (ctrl_q.out_en),
  .tx_empty (tx_empty_q),
  .tx_busy  (tx_busy),
  .rx_full  (rx_full_q),
  .rx_done  (rx_done),
  .err      (err_q)
);

// File: tb/sio_uart_tb.sv
module sio_uart_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rx_drv = 1'b1;
  logic        loop_en = 1'b0;
  logic        rxd, txd, tx_irq, rx_irq;

  always #2 clk = ~clk;
  assign rxd = loop_en ? txd : rx_drv;

  sio_uart u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (addr),
    .reg_wr    (wr),
    .reg_rd    (rd),
    .reg_wdata (wdata),
    .reg_rdata (rdata),
    .rxd_i     (rxd),
    .txd_o     (txd),
    .tx_irq_o  (tx_irq),
    .rx_irq_o  (rx_irq)
  );

  int     n_chk = 0;
  int     n_fail = 0;
  longint cyc = 0;
  bit     finished = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  function automatic logic [11:0] exp_frame(input int m, input int par, input int odd,
                                            input int two, input int nin,
                                            input logic [7:0] d, output int len);
    logic [11:0] f;
    logic p;
    int nd, pos;
    nd = (m == 0) ? 7 : 8;
    f = '1; f[0] = 1'b0; p = odd[0];
    for (int i = 0; i < nd; i++) begin
      f[1+i] = d[i];
      p ^= d[i];
    end
    pos = 1 + nd;
    if (par != 0) begin f[pos] = p; pos++; end
    else if (m == 3) begin f[pos] = nin[0]; pos++; end
    len = pos + ((two != 0) ? 2 : 1);
    return f;
  endfunction

  task automatic decode(input int per, input int len, output logic [11:0] bits, output longint t0);
    bits = '1;
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    t0 = cyc;
    repeat (per / 2) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      bits[i] = txd;
      if (i < len - 1) repeat (per) @(negedge clk);
    end
  endtask

  task automatic drive_frame(input logic [11:0] f, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_drv = f[i];
      repeat (15) @(negedge clk);
    end
    @(negedge clk);
    rx_drv = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  logic [15:0] s, v;
  logic [11:0] fa, fb, ga, gb;
  logic [7:0]  da, db;
  longint      t0, t1;
  int          len, lows;
  logic        exp_rx9 = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    chk("R11 txd idle", txd, 1);
    chk("R11 irqs", {tx_irq, rx_irq}, 0);
    rd_reg(3'd0, v); chk("R11 ctrl", v, 0);
    rd_reg(3'd1, v); chk("R11 status", v, 16'h0004);
    rd_reg(3'd4, v); chk("R11 divisor", v, 0);

    // R2: reserved mode code ignored
    wr_reg(3'd0, 16'h0025);
    rd_reg(3'd0, v); chk("R2 ctrl write", v, 16'h0025);
    wr_reg(3'd0, 16'h005E);
    rd_reg(3'd0, v); chk("R2 reserved mode ignored", v, 16'h0025);

    // Sweep over every mode and option combination with loopback (R1 R3 R4 R8 R9)
    loop_en = 1'b1;
    for (int m = 0; m < 4; m++) begin
      if (m == 2) continue;
      for (int c = 0; c < 16; c++) begin
        int par, odd, two, nin;
        par = c & 1; odd = (c >> 1) & 1; two = (c >> 2) & 1; nin = (c >> 3) & 1;
        wr_reg(3'd0, 16'(m | (par << 2) | (odd << 3) | (two << 4) | (1 << 5) | (nin << 6)));
        da = 8'((8'h3C ^ ((m * 16 + c) * 29)) & 8'hFF);
        db = ~da;
        fa = exp_frame(m, par, odd, two, nin, da, len);
        fb = exp_frame(m, par, odd, two, nin, db, len);
        fork
          begin
            wr_reg(3'd3, {8'h00, da});
            do rd_reg(3'd1, s); while (s[2] == 1'b0);
            wr_reg(3'd3, {8'h00, db});
          end
          begin
            decode(16, len, ga, t0);
            decode(16, len, gb, t1);
          end
        join
        chk("R1 R3 frame A", ga, fa);
        chk("R1 R3 frame B", gb, fb);
        chk("R4 frame spacing", t1 - t0, 16 * len + 1);
        repeat (40) @(negedge clk);
        if (m == 3 && par == 0) exp_rx9 = nin[0];
        rd_reg(3'd1, s);
        chk("R9 R3 status after overrun", s[5:0], {exp_rx9, 5'b00111});
        rd_reg(3'd2, v);
        chk("R8 R9 kept first byte", v, {8'h00, da & ((m == 0) ? 8'h7F : 8'hFF)});
        rd_reg(3'd1, s);
        chk("R8 full cleared by read", s[1:0], 2'b10);
        wr_reg(3'd1, 16'h0002);
      end
    end
    loop_en = 1'b0;

    // R7: output disabled keeps line high, byte still consumed
    wr_reg(3'd0, 16'h0001);
    wr_reg(3'd3, 16'h00F0);
    lows = 0;
    repeat (300) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    chk("R7 no line activity", lows, 0);
    rd_reg(3'd1, s); chk("R5 R7 byte consumed", s[2], 1);

    // R5: write while holding register full is dropped
    wr_reg(3'd0, 16'h0021);
    fa = exp_frame(1, 0, 0, 0, 0, 8'h11, len);
    fb = exp_frame(1, 0, 0, 0, 0, 8'h22, len);
    fork
      begin
        wr_reg(3'd3, 16'h0011);
        do rd_reg(3'd1, s); while (s[2] == 1'b0);
        wr_reg(3'd3, 16'h0022);
        wr_reg(3'd3, 16'h0033);
        rd_reg(3'd1, s);
        chk("R5 empty cleared", s[2], 0);
      end
      begin
        decode(16, len, ga, t0);
        decode(16, len, gb, t1);
      end
    join
    chk("R5 first byte", ga, fa);
    chk("R5 second byte", gb, fb);
    lows = 0;
    repeat (400) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
    chk("R5 dropped byte not sent", lows, 0);

    // R6: transmit interrupt
    wr_reg(3'd1, 16'h0008);
    chk("R6 irq when empty", tx_irq, 1);
    wr_reg(3'd3, 16'h0055);
    wr_reg(3'd3, 16'h0066);
    chk("R6 irq low when full", tx_irq, 0);
    repeat (400) @(negedge clk);
    chk("R6 irq back", tx_irq, 1);
    wr_reg(3'd1, 16'h0000);
    chk("R6 irq masked", tx_irq, 0);

    // R1: divisor 2 gives 48-clock bits
    wr_reg(3'd4, 16'h0002);
    fa = exp_frame(1, 0, 0, 0, 0, 8'hC3, len);
    fork
      wr_reg(3'd3, 16'h00C3);
      decode(48, len, ga, t0);
    join
    chk("R1 frame at divisor 2", ga, fa);
    repeat (100) @(negedge clk);
    wr_reg(3'd4, 16'h0000);

    // R8 R10: direct receive, glitch rejection
    wr_reg(3'd1, 16'h0010);
    @(negedge clk); rx_drv = 1'b0;
    repeat (4) @(negedge clk); rx_drv = 1'b1;
    repeat (60) @(negedge clk);
    rd_reg(3'd1, s); chk("R8 glitch ignored", s[1:0], 0);
    chk("R10 irq idle", rx_irq, 0);
    fa = exp_frame(1, 0, 0, 0, 0, 8'hA5, len);
    drive_frame(fa, len);
    repeat (20) @(negedge clk);
    chk("R10 irq on full", rx_irq, 1);
    rd_reg(3'd2, v); chk("R8 received byte", v, 16'h00A5);
    chk("R10 irq after read", rx_irq, 0);

    // R9: low stop bit
    fa = exp_frame(1, 0, 0, 0, 0, 8'h3C, len);
    fa[len-1] = 1'b0;
    drive_frame(fa, len);
    repeat (20) @(negedge clk);
    rd_reg(3'd1, s); chk("R9 framing error", s[1:0], 2'b11);
    rd_reg(3'd2, v); chk("R9 data kept", v, 16'h003C);
    chk("R10 irq on error", rx_irq, 1);
    wr_reg(3'd1, 16'h0012);
    rd_reg(3'd1, s); chk("R9 error cleared", s[1:0], 0);
    chk("R10 irq cleared", rx_irq, 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule